// File: doc/BRIEF.md
# Dual-slope PWM timer

This block produces a centre-aligned pulse-width-modulated waveform. A prescaler turns the system clock into a timer tick. On each tick an up/down counter moves from zero to a programmable ceiling and then back to zero. The endpoint values are not repeated, so one full sweep lasts 2 × TOP ticks. A compare unit compares the counter with a programmable threshold and drives a single waveform output. The output can be turned off, can toggle on every match, or can give a non-inverted or inverted pulse that is symmetric about the ceiling.

Software programs the block through a small write port. The ceiling and the threshold are written to shadow registers. Their working copies change only when the counter is at zero, so no sweep ever mixes old and new settings. Two sticky status flags report events: one for a threshold match and one for reaching either endpoint. Writing a one to a flag's bit at the clear address clears that flag.

Top module: `dspwm_timer`

## Requirements
- R1: After reset the waveform output is low, both flags are clear, the control register is zero (stopped, output off), and nothing changes until software starts the timer.
- R2: Control bits [2:0] select the tick rate: 1 gives every clock, 2 gives every 8th, 3 every 64th, 4 every 256th and 5 every 1024th. Codes 0, 6 and 7 stop the timer. The counter moves only on a tick.
- R3: With a ceiling T > 0, the counter runs 0, 1, …, T, T−1, …, 1, 0, 1, … and repeats no endpoint. One sweep therefore takes 2·N·T clocks. A ceiling of 0 holds the counter at 0, and the counter never exceeds the working ceiling.
- R4: Mode field control bits [4:3] = 2 is non-inverted. The output goes high on a tick where the counter equals the threshold C while rising (including the tick at T). It goes low on such a tick while falling. For 0 < C < T it is high for 2·(T−C) ticks of each sweep.
- R5: Mode field value 3 gives the exact complement of the non-inverted waveform.
- R6: At each tick taken at zero, the non-inverted level is set to high if C ≥ T and C ≠ 0, and to low otherwise. So C = 0 gives a constantly low output and C ≥ T a constantly high one; inverted mode gives the opposite levels.
- R7: Mode field value 1 toggles the output on every match. With C = T this gives a 50 % square wave whose period is 4·N·T clocks.
- R8: Mode field value 0 holds the output low.
- R9: Writes to address 0 (ceiling) and address 1 (threshold) go to shadow registers. These are copied into the working registers only on a tick taken while the counter is at zero.
- R10: The match flag is set by a tick at which the counter equals the threshold. It stays set until a write to address 3 with bit 0 = 1 clears it; a match in the same cycle wins over the clear.
- R11: The endpoint flag is set by a tick taken at zero or at the ceiling. It stays set until a write to address 3 with bit 1 = 1 clears it, and it is independent of the match flag.
- R12: While the timer is stopped, the output level and both flags hold their values, except for clears written by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 ceiling, 1 threshold, 2 control, 3 flag clear |
| wr_data | input | CNT_W | Write data |
| wave_o | output | 1 | Waveform output |
| cmp_flag_o | output | 1 | Sticky threshold-match flag |
| end_flag_o | output | 1 | Sticky endpoint flag |

## Verification
The non-inverted waveform is tried with thresholds 1, 2 and 3 under one ceiling. The measured high time changes with each threshold, which shows that the set point on the rising slope and the clear point on the falling slope both follow the threshold. Thresholds of 0, equal to the ceiling and above it check that the fixed levels are reached and are not a stray one-tick pulse. The same threshold is then run in inverted, toggle and off modes, which tells the four mode encodings apart. Shadow-register writes are timed to land in the middle of a pulse: a pulse of the old length shows that the write was deferred, and a pulse of the new length afterwards shows that it was applied at zero. The tick rates are told apart by the interval between toggles.

// File: rtl/dspwm_pkg.sv
`timescale 1ns/1ps
package dspwm_pkg;

  typedef enum logic [1:0] {
    WAVE_OFF     = 2'd0,
    WAVE_TOGGLE  = 2'd1,
    WAVE_HIGH_UP = 2'd2,
    WAVE_LOW_UP  = 2'd3
  } wave_mode_e;

  localparam int PRE_W = 10;

  localparam logic [1:0] ADR_TOP  = 2'd0;
  localparam logic [1:0] ADR_CMP  = 2'd1;
  localparam logic [1:0] ADR_CTRL = 2'd2;
  localparam logic [1:0] ADR_CLR  = 2'd3;

  // low-bit mask whose all-ones pattern marks a tick for a divided rate
  function automatic logic [PRE_W-1:0] pre_mask(input logic [2:0] sel);
    case (sel)
      3'd2:    pre_mask = PRE_W'(10'h007);
      3'd3:    pre_mask = PRE_W'(10'h03F);
      3'd4:    pre_mask = PRE_W'(10'h0FF);
      3'd5:    pre_mask = PRE_W'(10'h3FF);
      default: pre_mask = '0;
    endcase
  endfunction

endpackage

// File: rtl/dspwm_prescaler.sv
`timescale 1ns/1ps
module dspwm_prescaler
  import dspwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  output logic       tick_o
);

  logic [PRE_W-1:0] div_q, div_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    div_d = div_q + PRE_W'(1);
    mask  = pre_mask(sel_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  always_comb begin
    case (sel_i)
      3'd1:                   tick_o = 1'b1;
      3'd2, 3'd3, 3'd4, 3'd5: tick_o = ((div_q & mask) == mask);
      default:                tick_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dspwm_counter.sv
`timescale 1ns/1ps
module dspwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic [CNT_W-1:0] top_o,
  output logic [CNT_W-1:0] cmp_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, top_q, top_d, cmp_q, cmp_d;
  logic             up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    top_d = top_q;
    cmp_d = cmp_q;
    if (tick_i) begin
      if (cnt_q == '0) begin
        top_d = top_buf_i;
        cmp_d = cmp_buf_i;
        if (top_buf_i != '0) begin
          cnt_d = CNT_W'(1);
          up_d  = 1'b1;
        end
      end else if (up_q && (cnt_q >= top_q)) begin
        cnt_d = cnt_q - CNT_W'(1);
        up_d  = 1'b0;
      end else if (up_q) begin
        cnt_d = cnt_q + CNT_W'(1);
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      top_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      top_q <= top_d;
      cmp_q <= cmp_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;
  assign top_o = top_q;
  assign cmp_o = cmp_q;

endmodule

// File: rtl/dspwm_compare.sv
`timescale 1ns/1ps
module dspwm_compare
  import dspwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  wave_mode_e       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] top_act_i,
  input  logic [CNT_W-1:0] cmp_act_i,
  input  logic [CNT_W-1:0] top_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  input  logic [1:0]       clr_i,
  output logic             wave_o,
  output logic             cmp_flag_o,
  output logic             end_flag_o
);

  logic             at_bot, hit, at_end;
  logic [CNT_W-1:0] cmp_eff, top_eff;
  logic             lvl_q, lvl_d, tog_q, tog_d;
  logic             cflag_q, cflag_d, eflag_q, eflag_d;

  always_comb begin
    at_bot  = (cnt_i == '0);
    cmp_eff = at_bot ? cmp_buf_i : cmp_act_i;
    top_eff = at_bot ? top_buf_i : top_act_i;
    hit     = tick_i && (cnt_i == cmp_eff);
    at_end  = tick_i && (at_bot || (up_i && (cnt_i == top_act_i)));

    lvl_d = lvl_q;
    if (tick_i && at_bot) lvl_d = (cmp_eff != '0) && (cmp_eff >= top_eff);
    else if (hit)         lvl_d = up_i;

    if (mode_i != WAVE_TOGGLE) tog_d = 1'b0;
    else                       tog_d = hit ? ~tog_q : tog_q;

    cflag_d = hit    | (cflag_q & ~clr_i[0]);
    eflag_d = at_end | (eflag_q & ~clr_i[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      tog_q   <= 1'b0;
      cflag_q <= 1'b0;
      eflag_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      tog_q   <= tog_d;
      cflag_q <= cflag_d;
      eflag_q <= eflag_d;
    end
  end

  always_comb begin
    case (mode_i)
      WAVE_TOGGLE:  wave_o = tog_q;
      WAVE_HIGH_UP: wave_o = lvl_q;
      WAVE_LOW_UP:  wave_o = ~lvl_q;
      default:      wave_o = 1'b0;
    endcase
  end

  assign cmp_flag_o = cflag_q;
  assign end_flag_o = eflag_q;

endmodule

// File: rtl/dspwm_timer.sv
`timescale 1ns/1ps
module dspwm_timer
  import dspwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             wave_o,
  output logic             cmp_flag_o,
  output logic             end_flag_o
);

  logic [CNT_W-1:0] top_buf_q, top_buf_d, cmp_buf_q, cmp_buf_d;
  logic [2:0]       sel_q, sel_d;
  wave_mode_e       mode_q, mode_d;
  logic [1:0]       clr_req;
  logic             tick, up_q;
  logic [CNT_W-1:0] cnt_q, top_act, cmp_act;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^wr_data[CNT_W-1:5];

  always_comb begin
    top_buf_d = top_buf_q;
    cmp_buf_d = cmp_buf_q;
    sel_d     = sel_q;
    mode_d    = mode_q;
    clr_req   = 2'b00;
    if (wr_en) begin
      case (wr_addr)
        ADR_TOP:  top_buf_d = wr_data;
        ADR_CMP:  cmp_buf_d = wr_data;
        ADR_CTRL: begin
          sel_d  = wr_data[2:0];
          mode_d = wave_mode_e'(wr_data[4:3]);
        end
        default:  clr_req = wr_data[1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_buf_q <= '0;
      cmp_buf_q <= '0;
      sel_q     <= 3'd0;
      mode_q    <= WAVE_OFF;
    end else begin
      top_buf_q <= top_buf_d;
      cmp_buf_q <= cmp_buf_d;
      sel_q     <= sel_d;
      mode_q    <= mode_d;
    end
  end

  dspwm_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  dspwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .top_buf_i (top_buf_q),
    .cmp_buf_i (cmp_buf_q),
    .cnt_o     (cnt_q),
    .up_o      (up_q),
    .top_o     (top_act),
    .cmp_o     (cmp_act)
  );

  dspwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .mode_i     (mode_q),
    .cnt_i      (cnt_q),
    .up_i       (up_q),
    .top_act_i  (top_act),
    .cmp_act_i  (cmp_act),
    .top_buf_i  (top_buf_q),
    .cmp_buf_i  (cmp_buf_q),
    .clr_i      (clr_req),
    .wave_o     (wave_o),
    .cmp_flag_o (cmp_flag_o),
    .end_flag_o (end_flag_o)
  );

endmodule

// File: rtl/dspwm_timer_chk.sv
`timescale 1ns/1ps
module dspwm_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             clr_bit,
  input logic             tick,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] top_act,
  input logic [CNT_W-1:0] cmp_act,
  input logic [1:0]       mode_q,
  input logic             wave_o,
  input logic             cmp_flag_o,
  input logic             end_flag_o
);

  assert_cnt_within_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= top_act);

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  assert_load_at_bottom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && (cnt_q == '0)) |=> ($stable(cmp_act) && $stable(top_act)));

  assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> !wave_o);

  assert_match_flag_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag_o) |-> $past(tick));

  assert_match_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 2'd3) && clr_bit && !tick) |=> !cmp_flag_o);

  assert_end_flag_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag_o) |-> $past(tick));

endmodule

bind dspwm_timer dspwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .clr_bit    (wr_data[0]),
  .tick       (tick),
  .cnt_q      (cnt_q),
  .top_act    (top_act),
  .cmp_act    (cmp_act),
  .mode_q     (mode_q),
  .wave_o     (wave_o),
  .cmp_flag_o (cmp_flag_o),
  .end_flag_o (end_flag_o)
);

// File: tb/dspwm_timer_bench.sv
`timescale 1ns/1ps
module dspwm_timer_bench;

  localparam int CNT_W = 16;

  logic             clk;
  logic             rst_n;
  logic             wr_en;
  logic [1:0]       wr_addr;
  logic [CNT_W-1:0] wr_data;
  logic             wave_o, cmp_flag_o, end_flag_o;

  int total = 0;
  int bad   = 0;

  dspwm_timer #(.CNT_W(CNT_W)) u_dspwm_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wave_o     (wave_o),
    .cmp_flag_o (cmp_flag_o),
    .end_flag_o (end_flag_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wave_o) h++;
    end
  endtask

  task automatic count_changes(input int n, output int e);
    logic p;
    e = 0;
    @(negedge clk);
    p = wave_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wave_o != p) e++;
      p = wave_o;
    end
  endtask

  task automatic sync_rise();
    logic p;
    int   n;
    n = 0;
    p = wave_o;
    @(negedge clk);
    while (!(!p && wave_o) && n < 5000) begin
      p = wave_o;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_pulse(output int len);
    len = 1;
    @(negedge clk);
    wr_en = 1'b0;
    while (wave_o && len < 200) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic change_gap(output int gap);
    logic p;
    int   n;
    n = 0;
    p = wave_o;
    @(negedge clk);
    while (wave_o == p && n < 5000) begin
      @(negedge clk);
      n++;
    end
    p   = wave_o;
    gap = 0;
    while (wave_o == p && gap < 5000) begin
      @(negedge clk);
      gap++;
    end
  endtask

  task automatic t_reset();
    chk("R1 wave after reset", int'(wave_o), 0);
    chk("R1 match flag after reset", int'(cmp_flag_o), 0);
    idle(20);
    chk("R1 endpoint flag stays clear while stopped", int'(end_flag_o), 0);
  endtask

  task automatic t_noninv();
    int h, e;
    wr(2'd0, 4);
    wr(2'd1, 1);
    wr(2'd2, 17);
    idle(24);
    count_high(8, h);
    chk("R4 high ticks T=4 C=1", h, 6);
    wr(2'd1, 2);
    idle(24);
    count_high(8, h);
    chk("R4 high ticks T=4 C=2", h, 4);
    wr(2'd1, 3);
    idle(24);
    count_high(8, h);
    chk("R4 high ticks T=4 C=3", h, 2);
    count_changes(32, e);
    chk("R3 sweep length 2*T gives 8 edges in 32 clocks", e, 8);
  endtask

  task automatic t_inverted();
    int h;
    wr(2'd1, 1);
    wr(2'd2, 25);
    idle(24);
    count_high(8, h);
    chk("R5 inverted high ticks T=4 C=1", h, 2);
  endtask

  task automatic t_corner();
    int h;
    wr(2'd2, 17);
    wr(2'd1, 0);
    idle(24);
    count_high(16, h);
    chk("R6 C=0 non-inverted always low", h, 0);
    wr(2'd1, 4);
    idle(24);
    count_high(16, h);
    chk("R6 C=T non-inverted always high", h, 16);
    wr(2'd1, 6);
    idle(24);
    count_high(16, h);
    chk("R6 C>T non-inverted always high", h, 16);
    wr(2'd1, 0);
    wr(2'd2, 25);
    idle(24);
    count_high(16, h);
    chk("R6 C=0 inverted always high", h, 16);
  endtask

  task automatic t_toggle();
    int h, e;
    wr(2'd1, 4);
    wr(2'd2, 9);
    idle(40);
    count_high(32, h);
    chk("R7 toggle C=T duty 50 percent", h, 16);
    count_changes(32, e);
    chk("R7 toggle C=T one change per 8 ticks", e, 4);
  endtask

  task automatic t_off();
    int h;
    wr(2'd2, 1);
    idle(4);
    count_high(32, h);
    chk("R8 mode 0 keeps output low", h, 0);
  endtask

  task automatic t_buffer();
    int len;
    wr(2'd1, 1);
    wr(2'd2, 17);
    idle(32);
    sync_rise();
    wr_en   = 1'b1;
    wr_addr = 2'd1;
    wr_data = CNT_W'(3);
    finish_pulse(len);
    chk("R9 pulse in flight keeps old threshold", len, 6);
    sync_rise();
    finish_pulse(len);
    chk("R9 new threshold used after bottom", len, 2);
    sync_rise();
    wr_en   = 1'b1;
    wr_addr = 2'd0;
    wr_data = CNT_W'(8);
    finish_pulse(len);
    chk("R9 pulse in flight keeps old ceiling", len, 2);
    sync_rise();
    finish_pulse(len);
    chk("R9 new ceiling used after bottom", len, 10);
  endtask

  task automatic t_flags();
    int  h;
    logic w0;
    int  same;
    wr(2'd2, 16);
    wr(2'd3, 3);
    chk("R10 match flag cleared by write", int'(cmp_flag_o), 0);
    chk("R11 endpoint flag cleared by write", int'(end_flag_o), 0);
    w0   = wave_o;
    same = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (wave_o == w0 && !cmp_flag_o && !end_flag_o) same++;
    end
    chk("R12 stopped output and flags hold", same, 30);
    wr(2'd1, 9);
    wr(2'd2, 17);
    idle(40);
    chk("R11 endpoint flag set while running", int'(end_flag_o), 1);
    wr(2'd3, 1);
    idle(40);
    chk("R10 no match with C>T keeps flag clear", int'(cmp_flag_o), 0);
    count_high(32, h);
    chk("R6 C>T long ceiling always high", h, 32);
    wr(2'd1, 3);
    idle(40);
    chk("R10 match sets flag", int'(cmp_flag_o), 1);
    wr(2'd2, 16);
    wr(2'd3, 2);
    chk("R11 bit 1 clears endpoint flag", int'(end_flag_o), 0);
    chk("R10 bit 1 leaves match flag", int'(cmp_flag_o), 1);
    wr(2'd3, 1);
    chk("R10 bit 0 clears match flag", int'(cmp_flag_o), 0);
  endtask

  task automatic t_prescale();
    int gap, n, e;
    wr(2'd0, 1);
    wr(2'd1, 1);
    wr(2'd2, 9);
    idle(40);
    for (int s = 1; s <= 5; s++) begin
      case (s)
        1:       n = 1;
        2:       n = 8;
        3:       n = 64;
        4:       n = 256;
        default: n = 1024;
      endcase
      wr(2'd2, 8 + s);
      change_gap(gap);
      chk($sformatf("R2 toggle gap for select %0d", s), gap, 2 * n);
    end
    wr(2'd2, 15);
    count_changes(300, e);
    chk("R2 select 7 stops the timer", e, 0);
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = 2'd0;
    wr_data = '0;
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_noninv();
    t_inverted();
    t_corner();
    t_toggle();
    t_off();
    t_buffer();
    t_flags();
    t_prescale();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule